// File: doc/BRIEF.md
# Slot-Indexed Result Buffer with Forwarding

The block keeps instruction results in a fixed set of numbered slots between execution and register-file writeback. An external token allocator hands each decoded instruction a slot and tells this block which slot is now owned. Results come back in any order, each tagged with its slot, destination register and value. A retire pointer walks the slots in cyclic order and writes each filled slot back to the register file, strictly in slot order. Each writeback also tells the allocator that the slot may be handed out again.

The decoder may also ask for a value before writeback. A request carries up to two candidate slots, newest first, each with a use bit. The block walks the list one entry per cycle:
- An unused entry, or a slot that owns nothing, is skipped.
- A slot that is allocated but still empty makes the walk wait until its result arrives.
- A filled slot answers with its value.

When every entry is skipped, the answer is a miss, and the decoder reads the register bank instead. While a request is outstanding, every slot it names holds a claim. A claimed slot is not retired, so it cannot be freed, reassigned and overwritten before the forward completes.

Top module: `rob_fwd_buffer`

## Requirements
- R1: After reset every slot owns nothing, the retire pointer is at slot 0, `fwd_req_ready_o` is 1, and `wb_valid_o`, `free_valid_o` and `fwd_rsp_valid_o` are 0.
- R2: `alloc_valid_i` turns a free slot into a pending slot. An allocation naming a slot that is pending or filled is ignored, and a filled slot keeps its value.
- R3: A result is stored in the slot named by `res_slot_i`, whatever the order of arrival, and the slot becomes filled. A result naming a free or already filled slot is ignored.
- R4: The retire pointer retires slots in cyclic order from slot 0 and waits on a slot that is not filled. While it points at a filled, unclaimed slot, `wb_valid_o` and `free_valid_o` are 1 in that cycle. In that cycle `wb_reg_o` and `wb_data_o` carry the slot's contents and `free_slot_o` carries its number. The slot is freed and the pointer advances at the next edge.
- R5: A request is accepted on a cycle with `fwd_req_valid_i` and `fwd_req_ready_o` both 1. `fwd_req_ready_o` stays 0 from the edge after acceptance until the response cycle, which lasts one cycle, and is 1 again in the following cycle.
- R6: Entry k of a request sits at bits [k*3 +: 3] of `fwd_req_slots_i`, with use bit k of `fwd_req_use_i`, and entry 0 is the newest. The walk decides entry k in the (k+1)-th cycle after acceptance. For the first used entry that is filled, the response gives `fwd_rsp_hit_o`=1 and that slot's value.
- R7: If the walk reaches a pending slot, it waits with no response. The hit response comes in the cycle after the edge that writes that slot's result.
- R8: An entry with use bit 0, or one naming a free slot, is skipped. If all entries are skipped, the response in the second cycle after acceptance is a miss: `fwd_rsp_hit_o`=0 and `fwd_rsp_data_o`=0.
- R9: From the acceptance cycle until the edge after its response, a request holds a claim on each slot it names. The retire pointer does not retire a claimed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| alloc_valid_i | input | 1 | a slot has been assigned to an instruction |
| alloc_slot_i | input | 3 | slot being assigned |
| res_valid_i | input | 1 | a result is arriving |
| res_slot_i | input | 3 | slot the result belongs to |
| res_reg_i | input | 5 | destination register of the result |
| res_data_i | input | 32 | result value |
| fwd_req_valid_i | input | 1 | forwarding request present |
| fwd_req_ready_o | output | 1 | forwarding walker idle |
| fwd_req_slots_i | input | 6 | candidate slots, entry 0 newest in the low bits |
| fwd_req_use_i | input | 2 | use bit per candidate entry |
| fwd_rsp_valid_o | output | 1 | forwarding response, one cycle |
| fwd_rsp_hit_o | output | 1 | 1: value from a slot, 0: read the register bank |
| fwd_rsp_data_o | output | 32 | forwarded value, 0 on a miss |
| wb_valid_o | output | 1 | register-file write this cycle |
| wb_reg_o | output | 5 | register written |
| wb_data_o | output | 32 | value written |
| free_valid_o | output | 1 | slot released to the allocator |
| free_slot_o | output | 3 | released slot, equal to the retire pointer |

## Verification
The forwarding walk is swept over every pair of candidate slots, every combination of free, pending and filled state, and every pattern of use bits. This separates skipping from waiting from hitting, and shows whether the older entry is consulted only after the newer one is skipped, with the latency set by the deciding entry's position. Each setup also sends an allocation and a result to slots that should ignore them, and the forward outcome reveals whether either took effect. A retire sweep fills the slots in reverse order, then in order, to show that writeback follows slot order and not arrival order. A claim sequence leaves a filled slot under the retire pointer while a request waits, so it separates blocked retirement from normal retirement.

// File: rtl/rob_fwd_pkg.sv
package rob_fwd_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_FULL = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rob_slot_array.sv
module rob_slot_array
  import rob_fwd_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int CNT_W  = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               alloc_valid_i,
  input  logic [SLOT_W-1:0]                  alloc_slot_i,
  input  logic                               res_valid_i,
  input  logic [SLOT_W-1:0]                  res_slot_i,
  input  logic [REG_W-1:0]                   res_reg_i,
  input  logic [DATA_W-1:0]                  res_data_i,
  input  logic                               retire_valid_i,
  input  logic [SLOT_W-1:0]                  retire_slot_i,
  input  logic [SLOTS-1:0][CNT_W-1:0]        claim_i,
  input  logic [SLOTS-1:0][CNT_W-1:0]        release_i,
  output slot_state_e [SLOTS-1:0]            state_o,
  output logic [SLOTS-1:0][REG_W-1:0]        reg_o,
  output logic [SLOTS-1:0][DATA_W-1:0]       data_o,
  output logic [SLOTS-1:0][CNT_W-1:0]        cnt_o
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    slot_state_e       st_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              alloc_sel, res_sel, ret_sel;

    assign alloc_sel = alloc_valid_i && (alloc_slot_i == SLOT_W'(g));
    assign res_sel   = res_valid_i && (res_slot_i == SLOT_W'(g));
    assign ret_sel   = retire_valid_i && (retire_slot_i == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= SLOT_FREE;
        reg_q  <= '0;
        data_q <= '0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + claim_i[g] - release_i[g];
        unique case (st_q)
          SLOT_FREE: if (alloc_sel) st_q <= SLOT_WAIT;
          SLOT_WAIT: if (res_sel) begin
            st_q   <= SLOT_FULL;
            reg_q  <= res_reg_i;
            data_q <= res_data_i;
          end
          SLOT_FULL: if (ret_sel) st_q <= SLOT_FREE;
          default:   st_q <= SLOT_FREE;
        endcase
      end
    end

    assign state_o[g] = st_q;
    assign reg_o[g]   = reg_q;
    assign data_o[g]  = data_q;
    assign cnt_o[g]   = cnt_q;
  end

endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl
  import rob_fwd_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int CNT_W  = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  slot_state_e [SLOTS-1:0]      state_i,
  input  logic [SLOTS-1:0][REG_W-1:0]  reg_i,
  input  logic [SLOTS-1:0][DATA_W-1:0] data_i,
  input  logic [SLOTS-1:0][CNT_W-1:0]  cnt_i,
  input  logic [SLOTS-1:0][CNT_W-1:0]  claim_i,
  output logic                         retire_valid_o,
  output logic [SLOT_W-1:0]            retire_slot_o,
  output logic [REG_W-1:0]             wb_reg_o,
  output logic [DATA_W-1:0]            wb_data_o
);

  logic [SLOT_W-1:0] ptr_q;
  logic              blocked;

  // a claim taken in this very cycle also blocks retirement
  assign blocked        = (cnt_i[ptr_q] != '0) || (claim_i[ptr_q] != '0);
  assign retire_valid_o = (state_i[ptr_q] == SLOT_FULL) && !blocked;
  assign retire_slot_o  = ptr_q;
  assign wb_reg_o       = reg_i[ptr_q];
  assign wb_data_o      = data_i[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (retire_valid_o) begin
      ptr_q <= (ptr_q == SLOT_W'(SLOTS - 1)) ? '0 : ptr_q + SLOT_W'(1);
    end
  end

endmodule

// File: rtl/rob_fwd_walker.sv
module rob_fwd_walker
  import rob_fwd_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 32,
  parameter int LIST_N = 2,
  parameter int CNT_W  = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int IDX_W  = (LIST_N > 1) ? $clog2(LIST_N) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_valid_i,
  output logic                             req_ready_o,
  input  logic [LIST_N-1:0][SLOT_W-1:0]    req_slots_i,
  input  logic [LIST_N-1:0]                req_use_i,
  input  slot_state_e [SLOTS-1:0]          state_i,
  input  logic [SLOTS-1:0][DATA_W-1:0]     data_i,
  output logic                             rsp_valid_o,
  output logic                             rsp_hit_o,
  output logic [DATA_W-1:0]                rsp_data_o,
  output logic [SLOTS-1:0][CNT_W-1:0]      claim_o,
  output logic [SLOTS-1:0][CNT_W-1:0]      release_o
);

  logic                          busy_q;
  logic [IDX_W-1:0]              idx_q;
  logic [LIST_N-1:0][SLOT_W-1:0] slots_q;
  logic [LIST_N-1:0]             use_q;

  logic [SLOT_W-1:0] cur_slot;
  slot_state_e       cur_st;
  logic              cur_use, last, skip, hit, accept;

  assign accept      = req_valid_i && !busy_q;
  assign req_ready_o = !busy_q;

  assign cur_slot = slots_q[idx_q];
  assign cur_use  = use_q[idx_q];
  assign cur_st   = state_i[cur_slot];
  assign last     = (idx_q == IDX_W'(LIST_N - 1));
  assign skip     = !cur_use || (cur_st == SLOT_FREE);
  assign hit      = cur_use && (cur_st == SLOT_FULL);

  assign rsp_valid_o = busy_q && (hit || (skip && last));
  assign rsp_hit_o   = busy_q && hit;
  assign rsp_data_o  = (busy_q && hit) ? data_i[cur_slot] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      slots_q <= '0;
      use_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      slots_q <= req_slots_i;
      use_q   <= req_use_i;
    end else if (busy_q) begin
      if (rsp_valid_o) busy_q <= 1'b0;
      else if (skip)   idx_q  <= idx_q + IDX_W'(1);
    end
  end

  // claims taken on acceptance, all dropped on the response
  always_comb begin
    claim_o   = '0;
    release_o = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int k = 0; k < LIST_N; k++) begin
        if (accept && req_use_i[k] && (req_slots_i[k] == SLOT_W'(s)))
          claim_o[s] = claim_o[s] + CNT_W'(1);
        if (rsp_valid_o && use_q[k] && (slots_q[k] == SLOT_W'(s)))
          release_o[s] = release_o[s] + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rob_fwd_buffer.sv
module rob_fwd_buffer
  import rob_fwd_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int LIST_N = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W  = $clog2(LIST_N + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     alloc_valid_i,
  input  logic [SLOT_W-1:0]        alloc_slot_i,
  input  logic                     res_valid_i,
  input  logic [SLOT_W-1:0]        res_slot_i,
  input  logic [REG_W-1:0]         res_reg_i,
  input  logic [DATA_W-1:0]        res_data_i,
  input  logic                     fwd_req_valid_i,
  output logic                     fwd_req_ready_o,
  input  logic [LIST_N*SLOT_W-1:0] fwd_req_slots_i,
  input  logic [LIST_N-1:0]        fwd_req_use_i,
  output logic                     fwd_rsp_valid_o,
  output logic                     fwd_rsp_hit_o,
  output logic [DATA_W-1:0]        fwd_rsp_data_o,
  output logic                     wb_valid_o,
  output logic [REG_W-1:0]         wb_reg_o,
  output logic [DATA_W-1:0]        wb_data_o,
  output logic                     free_valid_o,
  output logic [SLOT_W-1:0]        free_slot_o
);

  slot_state_e [SLOTS-1:0]      slot_state;
  logic [SLOTS-1:0][REG_W-1:0]  slot_reg;
  logic [SLOTS-1:0][DATA_W-1:0] slot_data;
  logic [SLOTS-1:0][CNT_W-1:0]  slot_cnt;
  logic [SLOTS-1:0][CNT_W-1:0]  claim_cnt;
  logic [SLOTS-1:0][CNT_W-1:0]  release_cnt;
  logic [LIST_N-1:0][SLOT_W-1:0] req_list;
  logic                         retire_valid;
  logic [SLOT_W-1:0]            retire_slot;

  assign req_list = fwd_req_slots_i;

  rob_slot_array #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) u_array (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .alloc_valid_i  (alloc_valid_i),
    .alloc_slot_i   (alloc_slot_i),
    .res_valid_i    (res_valid_i),
    .res_slot_i     (res_slot_i),
    .res_reg_i      (res_reg_i),
    .res_data_i     (res_data_i),
    .retire_valid_i (retire_valid),
    .retire_slot_i  (retire_slot),
    .claim_i        (claim_cnt),
    .release_i      (release_cnt),
    .state_o        (slot_state),
    .reg_o          (slot_reg),
    .data_o         (slot_data),
    .cnt_o          (slot_cnt)
  );

  rob_retire_ctrl #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) u_retire (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .state_i        (slot_state),
    .reg_i          (slot_reg),
    .data_i         (slot_data),
    .cnt_i          (slot_cnt),
    .claim_i        (claim_cnt),
    .retire_valid_o (retire_valid),
    .retire_slot_o  (retire_slot),
    .wb_reg_o       (wb_reg_o),
    .wb_data_o      (wb_data_o)
  );

  rob_fwd_walker #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .LIST_N(LIST_N), .CNT_W(CNT_W)
  ) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (fwd_req_valid_i),
    .req_ready_o (fwd_req_ready_o),
    .req_slots_i (req_list),
    .req_use_i   (fwd_req_use_i),
    .state_i     (slot_state),
    .data_i      (slot_data),
    .rsp_valid_o (fwd_rsp_valid_o),
    .rsp_hit_o   (fwd_rsp_hit_o),
    .rsp_data_o  (fwd_rsp_data_o),
    .claim_o     (claim_cnt),
    .release_o   (release_cnt)
  );

  assign wb_valid_o   = retire_valid;
  assign free_valid_o = retire_valid;
  assign free_slot_o  = retire_slot;

endmodule

// File: rtl/rob_fwd_buffer_chk.sv
module rob_fwd_buffer_chk #(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wb_valid_o,
  input logic [SLOT_W-1:0]           free_slot_o,
  input logic                        fwd_req_valid_i,
  input logic                        fwd_req_ready_o,
  input logic                        fwd_rsp_valid_o,
  input logic                        fwd_rsp_hit_o,
  input logic [DATA_W-1:0]           fwd_rsp_data_o,
  input logic [SLOTS-1:0][CNT_W-1:0] slot_cnt
);

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> free_slot_o == (($past(free_slot_o) == SLOT_W'(SLOTS - 1)) ?
                                   SLOT_W'(0) : $past(free_slot_o) + SLOT_W'(1)));

  assert_ptr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_o |=> $stable(free_slot_o));

  assert_busy_after_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_req_valid_i && fwd_req_ready_o) |=> !fwd_req_ready_o);

  assert_rsp_while_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_rsp_valid_o |-> !fwd_req_ready_o);

  assert_ready_after_rsp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_rsp_valid_o |=> fwd_req_ready_o);

  assert_hit_in_rsp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_rsp_hit_o |-> fwd_rsp_valid_o);

  assert_miss_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_rsp_valid_o && !fwd_rsp_hit_o) |-> fwd_rsp_data_o == '0);

  assert_claim_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> slot_cnt[free_slot_o] == '0);

endmodule

bind rob_fwd_buffer rob_fwd_buffer_chk #(
  .SLOTS(SLOTS), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wb_valid_o      (wb_valid_o),
  .free_slot_o     (free_slot_o),
  .fwd_req_valid_i (fwd_req_valid_i),
  .fwd_req_ready_o (fwd_req_ready_o),
  .fwd_rsp_valid_o (fwd_rsp_valid_o),
  .fwd_rsp_hit_o   (fwd_rsp_hit_o),
  .fwd_rsp_data_o  (fwd_rsp_data_o),
  .slot_cnt        (slot_cnt)
);

// File: tb/rob_fwd_buffer_test.sv
`timescale 1ns/1ps
module rob_fwd_buffer_test;
  localparam int SLOTS = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_v = 1'b0;
  logic [SW-1:0] alloc_s = '0;
  logic res_v = 1'b0;
  logic [SW-1:0] res_s = '0;
  logic [4:0] res_r = '0;
  logic [31:0] res_d = '0;
  logic req_v = 1'b0;
  logic req_rdy;
  logic [2*SW-1:0] req_sl = '0;
  logic [1:0] req_use = '0;
  logic rsp_v, rsp_hit;
  logic [31:0] rsp_d;
  logic wb_v;
  logic [4:0] wb_r;
  logic [31:0] wb_d;
  logic fr_v;
  logic [SW-1:0] fr_s;

  int total = 0;
  int bad = 0;
  int mst [SLOTS];
  logic [31:0] mdat [SLOTS];

  always #10 clk = ~clk;

  rob_fwd_buffer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_v), .alloc_slot_i(alloc_s),
    .res_valid_i(res_v), .res_slot_i(res_s), .res_reg_i(res_r), .res_data_i(res_d),
    .fwd_req_valid_i(req_v), .fwd_req_ready_o(req_rdy),
    .fwd_req_slots_i(req_sl), .fwd_req_use_i(req_use),
    .fwd_rsp_valid_o(rsp_v), .fwd_rsp_hit_o(rsp_hit), .fwd_rsp_data_o(rsp_d),
    .wb_valid_o(wb_v), .wb_reg_o(wb_r), .wb_data_o(wb_d),
    .free_valid_o(fr_v), .free_slot_o(fr_s)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; alloc_v = 0; res_v = 0; req_v = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < SLOTS; s++) mst[s] = 0;
  endtask

  task automatic do_alloc(input int s);
    alloc_v = 1'b1; alloc_s = SW'(s);
    @(negedge clk);
    alloc_v = 1'b0;
    if (mst[s] == 0) mst[s] = 1;
  endtask

  task automatic do_write(input int s, input logic [4:0] r, input logic [31:0] d);
    res_v = 1'b1; res_s = SW'(s); res_r = r; res_d = d;
    @(negedge clk);
    res_v = 1'b0;
    if (mst[s] == 1) begin mst[s] = 2; mdat[s] = d; end
  endtask

  task automatic setup(input int s, input int st);
    logic [31:0] d;
    d = 32'hA000_0000 | (s << 8) | st;
    if (st == 0) begin
      do_write(s, 5'd1, 32'hBAD0_0000 | s);   // ignored: slot is free
    end else if (st == 1) begin
      do_alloc(s);
    end else begin
      do_alloc(s);
      do_write(s, 5'(s + 3), d);
      do_alloc(s);                            // ignored: slot is filled
      do_write(s, 5'd2, 32'hDEAD_0000 | s);   // ignored: slot is filled
    end
  endtask

  task automatic fwd_case(input int a, input int b, input int sa, input int sb, input int mask);
    int exp_c, exp_kind, ws, c;
    logic [31:0] exp_d, wd;
    do_reset();
    do_alloc(0);                              // holds the retire pointer
    setup(a, sa);
    if (b != a) setup(b, sb);
    exp_kind = 0; exp_c = 2; exp_d = '0; ws = 0;
    for (int k = 0; k < 2; k++) begin
      int s;
      s = (k == 0) ? a : b;
      if (mask[k] && mst[s] != 0) begin
        exp_kind = mst[s]; exp_c = k + 1; ws = s;
        exp_d = (mst[s] == 2) ? mdat[s] : '0;
        break;
      end
    end
    chk("R5 ready before request", 32'(req_rdy), 32'd1);
    req_v = 1'b1; req_sl = {SW'(b), SW'(a)}; req_use = 2'(mask);
    @(negedge clk);
    req_v = 1'b0;
    if (exp_kind == 1) begin
      for (int i = 0; i < 3; i++) begin
        chk("R7 no response while pending", 32'(rsp_v), 32'd0);
        chk("R5 busy while pending", 32'(req_rdy), 32'd0);
        @(negedge clk);
      end
      wd = 32'h7700_0000 | (a << 12) | (b << 4) | mask;
      do_write(ws, 5'd9, wd);
      chk("R7 response after arrival", 32'(rsp_v), 32'd1);
      chk("R7 hit after arrival", 32'(rsp_hit), 32'd1);
      chk("R7 data after arrival", rsp_d, wd);
    end else begin
      c = 1;
      while (!rsp_v && c < 8) begin @(negedge clk); c++; end
      chk(exp_kind == 2 ? "R6 hit latency" : "R8 miss latency", 32'(c), 32'(exp_c));
      chk(exp_kind == 2 ? "R6 hit flag" : "R8 miss flag", 32'(rsp_hit), 32'(exp_kind == 2));
      chk(exp_kind == 2 ? "R6 hit data" : "R8 miss data", rsp_d, exp_d);
    end
    @(negedge clk);
    chk("R5 ready after response", 32'(req_rdy), 32'd1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(req_rdy), 32'd1);
    chk("R1 wb", 32'(wb_v), 32'd0);
    chk("R1 free", 32'(fr_v), 32'd0);
    chk("R1 rsp", 32'(rsp_v), 32'd0);
    chk("R1 pointer", 32'(fr_s), 32'd0);
    do_reset();

    // R4/R3: out of order arrival, in-order writeback
    for (int s = 0; s < SLOTS; s++) do_alloc(s);
    for (int s = SLOTS - 1; s >= 1; s--) do_write(s, 5'(s + 1), 32'h5000_0000 + s * 17);
    chk("R4 waits on unfilled slot 0", 32'(wb_v), 32'd0);
    do_write(0, 5'd1, 32'h5000_0000);
    for (int i = 0; i < SLOTS; i++) begin
      chk("R4 wb valid", 32'(wb_v), 32'd1);
      chk("R4 free valid", 32'(fr_v), 32'd1);
      chk("R4 free slot", 32'(fr_s), 32'(i));
      chk("R3 wb reg", 32'(wb_r), 32'(i + 1));
      chk("R3 wb data", wb_d, 32'h5000_0000 + i * 17);
      @(negedge clk);
    end
    chk("R4 idle after sweep", 32'(wb_v), 32'd0);
    do_write(0, 5'd4, 32'hBAD0_BAD0);
    chk("R3 write to free slot ignored", 32'(wb_v), 32'd0);
    for (int s = 0; s < SLOTS; s++) begin
      do_alloc(s);
      do_write(s, 5'(20 + s), 32'h6100_0000 | s);
      chk("R4 round two slot", 32'(fr_s), 32'(s));
      chk("R2 round two data", wb_d, 32'h6100_0000 | s);
    end

    // R9: claimed filled slot is held until the response
    do_reset();
    do_alloc(0);
    do_alloc(1);
    req_v = 1'b1; req_sl = {SW'(0), SW'(1)}; req_use = 2'b11;
    @(negedge clk);
    req_v = 1'b0;
    do_write(0, 5'd7, 32'h0C0C_0C0C);
    for (int i = 0; i < 3; i++) begin
      chk("R9 claimed slot not retired", 32'(wb_v), 32'd0);
      @(negedge clk);
    end
    do_write(1, 5'd8, 32'h1D1D_1D1D);
    chk("R7 claim case response", 32'(rsp_v), 32'd1);
    chk("R7 claim case data", rsp_d, 32'h1D1D_1D1D);
    @(negedge clk);
    chk("R9 retired after release", 32'(wb_v), 32'd1);
    chk("R9 retired data", wb_d, 32'h0C0C_0C0C);
    @(negedge clk);
    chk("R4 next slot retired", 32'(fr_s), 32'd1);
    chk("R4 next slot data", wb_d, 32'h1D1D_1D1D);

    // R2/R3/R5..R8: forwarding sweep
    for (int a = 1; a < SLOTS; a++)
      for (int b = 1; b < SLOTS; b++)
        for (int sa = 0; sa < 3; sa++)
          for (int sb = 0; sb < 3; sb++)
            for (int m = 0; m < 4; m++)
              if (a != b || sa == sb) fwd_case(a, b, sa, sb, m);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule